// File: doc/BRIEF.md
# Posted-Write Latch for a Slow Peripheral Bus

This block sits between a processor-side request port and a slow external cartridge bus. It takes byte, halfword, word and doubleword requests, one per clock. A write is not carried out on the bus at once. It is posted into a single 32-bit holding register, and the block then reports the bus as occupied for a fixed number of cycles. During that window any further write is discarded without effect. A read that arrives during the window is not sent to the bus. It is answered from the holding register, it ends the window early, and it emits a one-clock stall request that carries the number of cycles that were still outstanding.

A read that arrives while the bus is free is served from the bus. In this project a small stub stands in for the bus and returns a fixed idle pattern. Every response is registered and appears one clock after the request. The occupied flag is also provided as a plain status output so that a register block can report it.

Top module: `pbusPostLatch`

## Requirements
- R1: A write request (`reqValid`=1, `reqWrite`=1) that arrives while `busy` is low is accepted. In the next cycle `accepted` is high for one clock and `busy` is high.
- R2: After an accepted write, `busy` stays high for exactly DONE_CYCLES consecutive cycles (default 100) and then clears, provided no read arrives during that time.
- R3: A write request that arrives while `busy` is high is discarded. In the next cycle `dropped` is high and `accepted` is low. The held value does not change, which a later read made while still busy shows.
- R4: Size codes are 0 byte, 1 halfword, 2 word, 3 doubleword. A byte write places `wrData[7:0]` in held bits 31:24 when `reqAddrLow`=0 and in bits 23:16 when `reqAddrLow`=1. All other held bits become zero.
- R5: A halfword write stores `wrData[15:0]` in held bits 31:16 and zeroes bits 15:0. A word write stores `wrData[31:0]`. A doubleword write stores `wrData[63:32]`.
- R6: A read request that arrives while `busy` is high cancels the pending completion. In the next cycle `busy` is low, `stallValid` is high for one clock, and `stallCycles` equals the number of busy cycles that remained, which is DONE_CYCLES minus the full busy cycles already spent after the accepting cycle.
- R7: A read answered from the held value returns it zero-extended on `rdData` as follows: a byte read gives bits 31:24, a halfword read gives bits 31:16, a word read gives all 32 bits, and a doubleword read gives the held value in bits 63:32 with zeros below.
- R8: A read request that arrives while `busy` is low goes to the bus. In the next cycle `rdData` carries the idle word IDLE_WORD repeated twice, masked to the low 8, 16, 32 or 64 bits by size, and `stallValid` stays low.
- R9: A synchronous reset clears `busy`, the countdown and all response outputs. After reset a read is served from the bus with no stall.
- R10: Each request produces exactly one of `accepted`, `dropped` or `rdValid` in the next cycle. A cycle without a request produces none of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 dword |
| reqAddrLow | input | 1 | Address bit 0, selects the byte lane for byte writes |
| wrData | input | 64 | Write data, right-aligned for its size |
| rdData | output | 64 | Read data, right-aligned, valid with rdValid |
| rdValid | output | 1 | Read response pulse |
| busy | output | 1 | Posted write outstanding (status) |
| accepted | output | 1 | Write accepted pulse |
| dropped | output | 1 | Write discarded pulse |
| stallValid | output | 1 | Stall request pulse |
| stallCycles | output | CNT_W | Remaining cycles at cancellation, valid with stallValid |

## Verification
The bench builds the block with DONE_CYCLES=7 and a non-uniform IDLE_WORD. With that short window, every cancellation point can be swept, from the first busy cycle through natural expiry and one cycle past it, for every pairing of write size, byte lane and read size. This exposes off-by-one errors in the remaining-cycle count and in the lane placement. The uneven idle pattern makes a wrong size mask visible. Discarded writes are injected at several points in the window, and each is followed by a read while still busy, so that any change to the held value shows up.

// File: rtl/pbusPostPkg.sv
package pbusPostPkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  // Strobes from control to datapath, valid in the request cycle
  typedef struct packed {
    logic loadLatch;  // accepted write: capture into holding register
    logic readLatch;  // read while busy: answer from holding register
    logic readBus;    // read while idle: answer from bus
  } ctlStrobes_t;
endpackage

// File: rtl/pbusIdleStub.sv
module pbusIdleStub #(
  parameter logic [31:0] IDLE_WORD = 32'hFFFF_FFFF
) (
  output logic [63:0] idleData
);
  // Stand-in for the external bus: always returns the idle pattern
  assign idleData = {IDLE_WORD, IDLE_WORD};
endmodule

// File: rtl/pbusPostCtrl.sv
module pbusPostCtrl
  import pbusPostPkg::*;
#(
  parameter int unsigned DONE_CYCLES = 100,
  parameter int unsigned CNT_W = $clog2(DONE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic             reqWrite,
  output ctlStrobes_t      strobes,
  output logic             busy,
  output logic             accepted,
  output logic             dropped,
  output logic             stallValid,
  output logic [CNT_W-1:0] stallCycles
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DONE_CYCLES);

  logic [CNT_W-1:0] remainCnt;
  logic             busyQ;
  logic             isWr;
  logic             isRd;

  always_comb begin
    isWr              = reqValid && reqWrite;
    isRd              = reqValid && !reqWrite;
    strobes.loadLatch = isWr && !busyQ;
    strobes.readLatch = isRd && busyQ;
    strobes.readBus   = isRd && !busyQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remainCnt   <= '0;
      busyQ       <= 1'b0;
      accepted    <= 1'b0;
      dropped     <= 1'b0;
      stallValid  <= 1'b0;
      stallCycles <= '0;
    end else begin
      accepted    <= strobes.loadLatch;
      dropped     <= isWr && busyQ;
      stallValid  <= strobes.readLatch;
      stallCycles <= strobes.readLatch ? remainCnt : '0;
      if (strobes.loadLatch) begin
        remainCnt <= LOAD_VAL;
        busyQ     <= 1'b1;
      end else if (strobes.readLatch) begin
        remainCnt <= '0;
        busyQ     <= 1'b0;
      end else if (busyQ) begin
        if (remainCnt == CNT_W'(1)) begin
          remainCnt <= '0;
          busyQ     <= 1'b0;
        end else begin
          remainCnt <= remainCnt - CNT_W'(1);
        end
      end
    end
  end

  assign busy = busyQ;
endmodule

// File: rtl/pbusPostData.sv
module pbusPostData
  import pbusPostPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ctlStrobes_t strobes,
  input  logic [1:0]  reqSize,
  input  logic        reqAddrLow,
  input  logic [63:0] wrData,
  input  logic [63:0] idleData,
  output logic [63:0] rdData,
  output logic        rdValid
);
  logic [31:0] latchQ;
  logic [31:0] placed;
  logic [63:0] fromLatch;
  logic [63:0] fromBus;

  // Write placement into the 32-bit holding register
  always_comb begin
    unique case (accSize_e'(reqSize))
      SZ_BYTE:  placed = reqAddrLow ? {8'h00, wrData[7:0], 16'h0000}
                                    : {wrData[7:0], 24'h000000};
      SZ_HALF:  placed = {wrData[15:0], 16'h0000};
      SZ_WORD:  placed = wrData[31:0];
      default:  placed = wrData[63:32];
    endcase
  end

  // Read formatting from holding register and from bus
  always_comb begin
    unique case (accSize_e'(reqSize))
      SZ_BYTE: begin
        fromLatch = {56'h0, latchQ[31:24]};
        fromBus   = {56'h0, idleData[7:0]};
      end
      SZ_HALF: begin
        fromLatch = {48'h0, latchQ[31:16]};
        fromBus   = {48'h0, idleData[15:0]};
      end
      SZ_WORD: begin
        fromLatch = {32'h0, latchQ};
        fromBus   = {32'h0, idleData[31:0]};
      end
      default: begin
        fromLatch = {latchQ, 32'h0};
        fromBus   = idleData;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latchQ  <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strobes.loadLatch) latchQ <= placed;
      rdValid <= strobes.readLatch || strobes.readBus;
      if (strobes.readLatch)    rdData <= fromLatch;
      else if (strobes.readBus) rdData <= fromBus;
      else                      rdData <= '0;
    end
  end
endmodule

// File: rtl/pbusPostLatch.sv
module pbusPostLatch
  import pbusPostPkg::*;
#(
  parameter int unsigned DONE_CYCLES = 100,
  parameter logic [31:0] IDLE_WORD = 32'hFFFF_FFFF,
  localparam int unsigned CNT_W = $clog2(DONE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       reqSize,
  input  logic             reqAddrLow,
  input  logic [63:0]      wrData,
  output logic [63:0]      rdData,
  output logic             rdValid,
  output logic             busy,
  output logic             accepted,
  output logic             dropped,
  output logic             stallValid,
  output logic [CNT_W-1:0] stallCycles
);
  ctlStrobes_t strobes;
  logic [63:0] idleData;

  pbusPostCtrl #(.DONE_CYCLES(DONE_CYCLES), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .strobes(strobes), .busy(busy), .accepted(accepted), .dropped(dropped),
    .stallValid(stallValid), .stallCycles(stallCycles)
  );

  pbusIdleStub #(.IDLE_WORD(IDLE_WORD)) uStub (.idleData(idleData));

  pbusPostData uData (
    .clk(clk), .rst(rst), .strobes(strobes), .reqSize(reqSize),
    .reqAddrLow(reqAddrLow), .wrData(wrData), .idleData(idleData),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/pbusPostChecker.sv
module pbusPostChecker #(
  parameter int unsigned DONE_CYCLES = 100,
  parameter int unsigned CNT_W = $clog2(DONE_CYCLES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             reqValid,
  input logic             reqWrite,
  input logic             rdValid,
  input logic             busy,
  input logic             accepted,
  input logic             dropped,
  input logic             stallValid,
  input logic [CNT_W-1:0] stallCycles
);
  logic [CNT_W:0] busyRun;

  always_ff @(posedge clk) begin
    if (rst || !busy) busyRun <= '0;
    else              busyRun <= busyRun + 1'b1;
  end

  assert_accept_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite && !busy) |=> (accepted && busy));

  assert_busy_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busyRun <= (CNT_W+1)'(DONE_CYCLES));

  assert_drop_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite && busy) |=> (dropped && !accepted));

  assert_cancel_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqWrite && busy) |=> (stallValid && !busy && stallCycles != '0));

  assert_stall_range_R6: assert property (@(posedge clk) disable iff (rst)
    stallValid |-> (stallCycles <= CNT_W'(DONE_CYCLES)));

  assert_idle_read_R8: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqWrite && !busy) |=> (rdValid && !stallValid));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!busy && !accepted && !dropped && !rdValid && !stallValid));

  assert_one_response_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({accepted, dropped, rdValid}));

  assert_no_request_R10: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !(accepted || dropped || rdValid));
endmodule

bind pbusPostLatch pbusPostChecker #(.DONE_CYCLES(DONE_CYCLES), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
  .rdValid(rdValid), .busy(busy), .accepted(accepted), .dropped(dropped),
  .stallValid(stallValid), .stallCycles(stallCycles)
);

// File: tb/tb_pbusPostLatch.sv
`timescale 1ns/1ps
module tb_pbusPostLatch;
  localparam int unsigned N = 7;
  localparam logic [31:0] IDLE = 32'hA5C3_1E7B;
  localparam int unsigned CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqAddrLow = 1'b0;
  logic [1:0] reqSize = 2'd0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic rdValid, busy, accepted, dropped, stallValid;
  logic [CW-1:0] stallCycles;

  int compared = 0;
  int mismatched = 0;
  int remain = 0;
  logic [31:0] mLatch = '0;
  string loadTag = "R5";
  bit done = 0;

  always #2 clk = ~clk;

  pbusPostLatch #(.DONE_CYCLES(N), .IDLE_WORD(IDLE)) dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddrLow(reqAddrLow), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .busy(busy), .accepted(accepted),
    .dropped(dropped), .stallValid(stallValid), .stallCycles(stallCycles)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] placeExp(input logic [1:0] sz, input logic a, input logic [63:0] d);
    case (sz)
      2'd0: return 32'(d[7:0]) << (24 - 8 * int'(a));   // R4
      2'd1: return 32'(d[15:0]) << 16;                   // R5
      2'd2: return d[31:0];
      default: return d[63:32];
    endcase
  endfunction

  function automatic logic [63:0] latchExp(input logic [1:0] sz, input logic [31:0] l);
    case (sz)
      2'd0: return 64'(l >> 24);
      2'd1: return 64'(l >> 16);
      2'd2: return 64'(l);
      default: return {l, 32'h0};
    endcase
  endfunction

  function automatic logic [63:0] idleExp(input logic [1:0] sz);
    logic [63:0] full = {IDLE, IDLE};
    case (sz)
      2'd0: return full & 64'hFF;
      2'd1: return full & 64'hFFFF;
      2'd2: return full & 64'hFFFF_FFFF;
      default: return full;
    endcase
  endfunction

  // One request (or idle cycle); called and returns at a falling edge
  task automatic step(input logic v, input logic w, input logic [1:0] sz,
                      input logic a, input logic [63:0] d);
    bit isBusy = remain > 0;
    bit eAcc = v && w && !isBusy;
    bit eDrop = v && w && isBusy;
    bit eStall = v && !w && isBusy;
    bit eRd = v && !w;
    logic [63:0] eData;
    int eCnt = eStall ? remain : 0;
    int newRemain;
    eData = eStall ? latchExp(sz, mLatch) : (eRd ? idleExp(sz) : 64'h0);
    newRemain = eAcc ? N : (eStall ? 0 : (isBusy ? remain - 1 : 0));
    reqValid = v; reqWrite = w; reqSize = sz; reqAddrLow = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check("R1 accepted", 64'(accepted), 64'(eAcc));
    check("R3 dropped", 64'(dropped), 64'(eDrop));
    check("R10 rdValid", 64'(rdValid), 64'(eRd));
    check("R6 stallValid", 64'(stallValid), 64'(eStall));
    check("R6 stallCycles", 64'(stallCycles), 64'(eCnt));
    check("R2 busy", 64'(busy), 64'(newRemain > 0));
    if (eStall) check($sformatf("%s/R7 rdData", loadTag), rdData, eData);
    else if (eRd) check("R8 rdData", rdData, eData);
    if (eAcc) begin
      mLatch = placeExp(sz, a, d);
      loadTag = (sz == 2'd0) ? "R4" : "R5";
    end
    remain = newRemain;
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9 busy", 64'(busy), 64'h0);
    check("R9 accepted", 64'(accepted), 64'h0);
    check("R9 stallValid", 64'(stallValid), 64'h0);
    check("R9 rdValid", 64'(rdValid), 64'h0);

    // Sweep write size x lane x cancellation point x read size
    for (int ws = 0; ws < 4; ws++)
      for (int a = 0; a < 2; a++)
        for (int k = 0; k <= N + 1; k++)
          for (int rs = 0; rs < 4; rs++) begin
            logic [63:0] d = 64'h1357_9BDF_2468_ACE0 ^ 64'(ws * 4099 + a * 977 + k * 131 + rs * 17);
            step(1'b1, 1'b1, 2'(ws), 1'(a), d);
            for (int i = 0; i < k; i++) step(1'b0, 1'b0, 2'd0, 1'b0, 64'h0);
            step(1'b1, 1'b0, 2'(rs), 1'(a), 64'h0);
            while (remain > 0) step(1'b0, 1'b0, 2'd0, 1'b0, 64'h0);
          end

    // R3: discarded writes at several points keep the held value
    for (int p = 0; p < N - 1; p++) begin
      step(1'b1, 1'b1, 2'd2, 1'b0, 64'h0000_0000_C0DE_0000 + 64'(p));
      for (int i = 0; i < p; i++) step(1'b0, 1'b0, 2'd0, 1'b0, 64'h0);
      step(1'b1, 1'b1, 2'd3, 1'b1, 64'hFFFF_EEEE_DDDD_CCCC);
      step(1'b1, 1'b0, 2'd2, 1'b0, 64'h0);
    end

    // R9: reset during a pending write
    step(1'b1, 1'b1, 2'd1, 1'b0, 64'h0000_0000_0000_BEEF);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    remain = 0;
    check("R9 busy after mid reset", 64'(busy), 64'h0);
    step(1'b1, 1'b0, 2'd3, 1'b0, 64'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule